// File: doc/BRIEF.md
# Timer Channel with Selectable Counter Clear

A single 16-bit timer channel for use inside a larger timer unit. A counter advances on single-cycle count ticks. A control field chooses where those ticks come from. One choice is an internal tick taken from a free-running prescaler, which divides the system clock by 1, 2, 4 or 8. The other choice is an external clock pin. That pin is brought into the system clock domain through a two-flop synchronizer, and its rising edge, falling edge or both edges are counted, as an edge field selects. A phase-counting flag overrides both the source field and the edge field. While it is set, the counter advances only on step pulses from an external phase decoder.

Two general registers, A and B, sit beside the counter. Each one works in one of two modes:
- In compare mode, a count tick that arrives while the counter equals the register raises a one-cycle match strobe.
- In capture mode, a capture trigger copies the counter into the register and raises a capture strobe.

A clear-select field picks the event that resets the counter:
- no event,
- any event on register A,
- any event on register B,
- a shared clear driven by other channels that run in step with this one.

Top module: `tmr_chan`

## Requirements
- R1: After reset, the counter is 0, both general registers hold 16'hFFFF, and both the match strobes and the capture strobes are 0.
- R2: When clock-source bit 2 is 0, the channel uses the internal tick. Bits [1:0] = n then give one count every 2^n system cycles, taken from a 3-bit prescaler that is 0 just after reset. Each tick is the prescaler's n low bits all being ones (n = 0 counts every cycle). The edge field has no effect in this case.
- R3: When clock-source bit 2 is 1, the channel counts the synchronized external pin. Edge field 00 counts rising edges, 01 counts falling edges, and 10 or 11 counts both. A pin change applied before clock edge k changes the counter at edge k+2.
- R4: When the phase flag is 1, the counter advances once per phase-step pulse. The source field, the edge field and the external pin are all ignored.
- R5: A general register in compare mode (mode bit 0) that equals the counter in a cycle with a count tick raises its match strobe (bit 0 = A, bit 1 = B) for exactly the next cycle.
- R6: A general register in capture mode (mode bit 1) that gets a capture trigger loads the counter value and raises its capture strobe for the next cycle. A capture beats a write in the same cycle. A register in capture mode never raises a match.
- R7: With clear-select 00 the counter is never cleared, and it wraps from 16'hFFFF to 0.
- R8: Clear-select 01 clears the counter on a match or capture of register A, and clear-select 10 does the same for register B. The clear takes the place of the increment when both fall in the same cycle.
- R9: Clear-select 11 clears the counter when both the sync-enable input and the sync-clear input are 1. The sync-clear input is ignored while sync-enable is 0.
- R10: A capture that also clears the counter stores the count from before the clear.
- R11: A write pulse on bit i of the write-enable input loads the write data into general register i (0 = A, 1 = B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clk_src | input | 3 | Bit 2: 1 = external pin; bits [1:0]: internal divide select |
| cfg_edge_sel | input | 2 | External edge: 00 rising, 01 falling, 1x both |
| cfg_clr_sel | input | 2 | Clear source: 00 none, 01 A, 10 B, 11 shared sync clear |
| phase_mode | input | 1 | Phase-counting override |
| phase_step | input | 1 | Count pulse from the phase decoder |
| ext_clk_in | input | 1 | Asynchronous external clock pin |
| gr_cap_mode | input | 2 | Per register: 1 = capture, 0 = compare |
| cap_trig | input | 2 | Capture trigger pulses for A and B |
| gr_wr_en | input | 2 | Write enables for A and B |
| gr_wr_data | input | 16 | Write data |
| sync_en | input | 1 | Channel takes part in the shared clear |
| sync_clr | input | 1 | Shared clear request from other channels |
| cnt_val | output | 16 | Counter value |
| gra_val | output | 16 | General register A |
| grb_val | output | 16 | General register B |
| cmp_match | output | 2 | Registered match strobes |
| cap_strobe | output | 2 | Registered capture strobes |

## Verification
The bench drives the counter up to the value in a general register while clear-on-A or clear-on-B is selected. A design that let the increment win would run one count past the register's value. A design that cleared without waiting for a tick would shorten every period when the clock is divided. Captures are placed on the same cycle as a clear and on the same cycle as a write. A wrong ordering would store zero or the written data instead of the live count. The bench also toggles the external pin under every edge setting and with the phase flag set. It pulses the shared clear while it is disabled, and it runs the counter through its wrap. These catch a missing synchronizer delay, an edge polarity that is swapped, a phase override that leaks, and a clear that ignores its enable.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_BY_A = 2'b01,
    CLR_BY_B = 2'b10,
    CLR_SYNC = 2'b11
  } clr_sel_e;

  typedef enum logic [1:0] {
    EDGE_RISE   = 2'b00,
    EDGE_FALL   = 2'b01,
    EDGE_BOTH_0 = 2'b10,
    EDGE_BOTH_1 = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV_SEL_W   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIV_SEL_W:0] clk_src,
  input  logic [1:0]         edge_sel,
  input  logic               phase_mode,
  input  logic               phase_step,
  input  logic               ext_pin,
  output logic               tick
);
  import tmr_pkg::*;

  localparam int N_DIV = 1 << DIV_SEL_W;
  localparam int PSC_W = N_DIV - 1;

  logic [PSC_W-1:0]     psc_q;
  logic [N_DIV-1:0]     div_tick;
  logic [SYNC_STAGES:0] pin_sh;
  logic                 pin_now, pin_prev, pin_rise, pin_fall;
  logic                 ext_tick, int_tick;
  edge_sel_e            esel;

  always_ff @(posedge clk) begin
    if (rst) psc_q <= '0;
    else     psc_q <= psc_q + 1'b1;
  end

  for (genvar k = 0; k < N_DIV; k++) begin : g_div
    if (k == 0) begin : g_full
      assign div_tick[k] = 1'b1;
    end else begin : g_part
      assign div_tick[k] = &psc_q[k-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pin_sh <= '0;
    else     pin_sh <= {pin_sh[SYNC_STAGES-1:0], ext_pin};
  end

  assign pin_now  = pin_sh[SYNC_STAGES-1];
  assign pin_prev = pin_sh[SYNC_STAGES];
  assign pin_rise = pin_now & ~pin_prev;
  assign pin_fall = ~pin_now & pin_prev;
  assign esel     = edge_sel_e'(edge_sel);

  always_comb begin
    case (esel)
      EDGE_RISE: ext_tick = pin_rise;
      EDGE_FALL: ext_tick = pin_fall;
      default:   ext_tick = pin_rise | pin_fall;
    endcase
  end

  assign int_tick = div_tick[clk_src[DIV_SEL_W-1:0]];

  always_comb begin
    if (phase_mode)              tick = phase_step;
    else if (clk_src[DIV_SEL_W]) tick = ext_tick;
    else                         tick = int_tick;
  end
endmodule

// File: rtl/tmr_gen_reg.sv
module tmr_gen_reg #(
  parameter int         W       = 16,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic         tick,
  input  logic         cap_mode,
  input  logic         cap_trig,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] gr_q,
  output logic         evt,
  output logic         match_q,
  output logic         cap_q
);
  logic match_now, cap_now;

  assign match_now = ~cap_mode & tick & (cnt == gr_q);
  assign cap_now   = cap_mode & cap_trig;
  assign evt       = match_now | cap_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      gr_q    <= RST_VAL;
      match_q <= 1'b0;
      cap_q   <= 1'b0;
    end else begin
      if (cap_now)    gr_q <= cnt;
      else if (wr_en) gr_q <= wr_data;
      match_q <= match_now;
      cap_q   <= cap_now;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr,
  output logic [W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W     = 16,
  parameter int DIV_SEL_W = 2,
  parameter int N_GR      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIV_SEL_W:0] cfg_clk_src,
  input  logic [1:0]         cfg_edge_sel,
  input  logic [1:0]         cfg_clr_sel,
  input  logic               phase_mode,
  input  logic               phase_step,
  input  logic               ext_clk_in,
  input  logic [N_GR-1:0]    gr_cap_mode,
  input  logic [N_GR-1:0]    cap_trig,
  input  logic [N_GR-1:0]    gr_wr_en,
  input  logic [CNT_W-1:0]   gr_wr_data,
  input  logic               sync_en,
  input  logic               sync_clr,
  output logic [CNT_W-1:0]   cnt_val,
  output logic [CNT_W-1:0]   gra_val,
  output logic [CNT_W-1:0]   grb_val,
  output logic [N_GR-1:0]    cmp_match,
  output logic [N_GR-1:0]    cap_strobe
);
  import tmr_pkg::*;

  logic             cnt_tick;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] gr_q [N_GR];
  logic [N_GR-1:0]  gr_evt;
  clr_sel_e         csel;

  tmr_tick_gen #(.DIV_SEL_W(DIV_SEL_W), .SYNC_STAGES(2)) u_tick (
    .clk(clk), .rst(rst), .clk_src(cfg_clk_src), .edge_sel(cfg_edge_sel),
    .phase_mode(phase_mode), .phase_step(phase_step), .ext_pin(ext_clk_in),
    .tick(cnt_tick)
  );

  for (genvar i = 0; i < N_GR; i++) begin : g_gr
    tmr_gen_reg #(.W(CNT_W), .RST_VAL({CNT_W{1'b1}})) u_gr (
      .clk(clk), .rst(rst), .cnt(cnt_q), .tick(cnt_tick),
      .cap_mode(gr_cap_mode[i]), .cap_trig(cap_trig[i]),
      .wr_en(gr_wr_en[i]), .wr_data(gr_wr_data),
      .gr_q(gr_q[i]), .evt(gr_evt[i]),
      .match_q(cmp_match[i]), .cap_q(cap_strobe[i])
    );
  end

  assign csel = clr_sel_e'(cfg_clr_sel);

  always_comb begin
    case (csel)
      CLR_BY_A: cnt_clr = gr_evt[0];
      CLR_BY_B: cnt_clr = gr_evt[1];
      CLR_SYNC: cnt_clr = sync_en & sync_clr;
      default:  cnt_clr = 1'b0;
    endcase
  end

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(cnt_tick), .clr(cnt_clr), .cnt_q(cnt_q)
  );

  assign cnt_val = cnt_q;
  assign gra_val = gr_q[0];
  assign grb_val = gr_q[1];
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cfg_clr_sel,
  input logic             sync_en,
  input logic             sync_clr,
  input logic [1:0]       gr_cap_mode,
  input logic [1:0]       cap_trig,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] gra_val,
  input logic [1:0]       cmp_match
);
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cfg_clr_sel == 2'b11 && sync_en && sync_clr) |=> cnt_val == '0); // R9

  AST_CAP_LOADS: assert property (@(posedge clk) disable iff (rst)
    (gr_cap_mode[0] && cap_trig[0]) |=> gra_val == $past(cnt_val)); // R10

  AST_CAP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cfg_clr_sel == 2'b01 && gr_cap_mode[0] && cap_trig[0]) |=> cnt_val == '0); // R8

  AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) + 1'b1 || cnt_val == '0)); // R2

  AST_NO_SPURIOUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cfg_clr_sel == 2'b00 && cnt_val != '1) |=> (cnt_val != '0 || $past(cnt_val) == '0)); // R7

  AST_MATCH_NOT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    cmp_match[1] |-> $past(!gr_cap_mode[1])); // R6
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_clr_sel(cfg_clr_sel), .sync_en(sync_en),
  .sync_clr(sync_clr), .gr_cap_mode(gr_cap_mode), .cap_trig(cap_trig),
  .cnt_val(cnt_val), .gra_val(gra_val), .cmp_match(cmp_match)
);

// File: tb/tmr_chan_test.sv
module tmr_chan_test;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic [2:0]  cfg_clk_src = '0;
  logic [1:0]  cfg_edge_sel = '0, cfg_clr_sel = '0;
  logic        phase_mode = 0, phase_step = 0, ext_clk_in = 0;
  logic [1:0]  gr_cap_mode = '0, cap_trig = '0, gr_wr_en = '0;
  logic [15:0] gr_wr_data = '0;
  logic        sync_en = 0, sync_clr = 0;
  logic [15:0] cnt_val, gra_val, grb_val;
  logic [1:0]  cmp_match, cap_strobe;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  tmr_chan uut (
    .clk(clk), .rst(rst), .cfg_clk_src(cfg_clk_src), .cfg_edge_sel(cfg_edge_sel),
    .cfg_clr_sel(cfg_clr_sel), .phase_mode(phase_mode), .phase_step(phase_step),
    .ext_clk_in(ext_clk_in), .gr_cap_mode(gr_cap_mode), .cap_trig(cap_trig),
    .gr_wr_en(gr_wr_en), .gr_wr_data(gr_wr_data), .sync_en(sync_en),
    .sync_clr(sync_clr), .cnt_val(cnt_val), .gra_val(gra_val), .grb_val(grb_val),
    .cmp_match(cmp_match), .cap_strobe(cap_strobe)
  );

  // Scoreboard: expected output word per clock edge and the requirement it serves
  logic [51:0] exp_q[$];
  string       tag_q[$];

  // Bench-side model state, built from the requirements
  logic [15:0] m_cnt, m_ga, m_gb;
  logic [2:0]  m_psc, m_sh;

  task automatic model_reset();
    m_cnt = '0; m_ga = 16'hFFFF; m_gb = 16'hFFFF; m_psc = '0; m_sh = '0;
  endtask

  // Predict the next edge from current inputs, queue it, advance one cycle
  task automatic cycle(input string tag);
    logic t, rise, fall, ma, mb, ca, cb, clr;
    logic [15:0] n_cnt, n_ga, n_gb;
    if (phase_mode) t = phase_step;
    else if (!cfg_clk_src[2]) begin
      case (cfg_clk_src[1:0])
        2'd0: t = 1'b1;
        2'd1: t = m_psc[0];
        2'd2: t = &m_psc[1:0];
        default: t = &m_psc;
      endcase
    end else begin
      rise = m_sh[1] & ~m_sh[2];
      fall = ~m_sh[1] & m_sh[2];
      t = (cfg_edge_sel == 2'b00) ? rise : (cfg_edge_sel == 2'b01) ? fall : (rise | fall);
    end
    ma = !gr_cap_mode[0] && t && m_cnt == m_ga;
    mb = !gr_cap_mode[1] && t && m_cnt == m_gb;
    ca = gr_cap_mode[0] && cap_trig[0];
    cb = gr_cap_mode[1] && cap_trig[1];
    clr = (cfg_clr_sel == 2'b01 && (ma || ca)) || (cfg_clr_sel == 2'b10 && (mb || cb)) ||
          (cfg_clr_sel == 2'b11 && sync_en && sync_clr);
    n_cnt = clr ? 16'h0 : t ? m_cnt + 16'h1 : m_cnt;
    n_ga = ca ? m_cnt : gr_wr_en[0] ? gr_wr_data : m_ga;
    n_gb = cb ? m_cnt : gr_wr_en[1] ? gr_wr_data : m_gb;
    m_cnt = n_cnt; m_ga = n_ga; m_gb = n_gb;
    m_sh = {m_sh[1:0], ext_clk_in};
    m_psc = m_psc + 3'd1;
    exp_q.push_back({n_cnt, n_ga, n_gb, mb, ma, cb, ca});
    tag_q.push_back(tag);
    @(negedge clk);
    cap_trig = '0; gr_wr_en = '0; sync_clr = 0; phase_step = 0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    cap_trig = '0; gr_wr_en = '0; sync_clr = 0; phase_step = 0; ext_clk_in = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Monitor: compare what the design shows just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [51:0] e, a;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        a = {cnt_val, gra_val, grb_val, cmp_match, cap_strobe};
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", tg, a, e);
        end
      end
    end
  end

  initial begin
    #(190000 * 20);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    chk(cnt_val, 16'h0, "R1 counter");
    chk(gra_val, 16'hFFFF, "R1 register A");
    chk(grb_val, 16'hFFFF, "R1 register B");
    chk({cmp_match, cap_strobe}, 4'h0, "R1 strobes");

    // R11 then R8/R5: clear on A compare, divide by 1
    gr_wr_en = 2'b01; gr_wr_data = 16'd4; cycle("R11 write A");
    cfg_clr_sel = 2'b01; run(20, "R8 R5 clear on A");

    // R2: internal divides with the edge field varied
    cfg_clr_sel = 2'b00;
    cfg_edge_sel = 2'b01; cfg_clk_src = 3'b001; run(12, "R2 div2");
    cfg_edge_sel = 2'b11; cfg_clk_src = 3'b010; run(20, "R2 div4");
    cfg_clk_src = 3'b011; run(24, "R2 div8");

    // R8 clear on B at a divided rate
    gr_wr_en = 2'b10; gr_wr_data = 16'd3; cycle("R11 write B");
    cfg_clr_sel = 2'b10; cfg_clk_src = 3'b001; run(24, "R8 clear on B");

    // R6/R10: capture on A with clear on A
    cfg_clk_src = 3'b000; cfg_clr_sel = 2'b01; gr_cap_mode = 2'b01; run(6, "R6 capture mode no match");
    cap_trig = 2'b01; cycle("R10 capture then clear");
    run(5, "R10 after clear");
    cap_trig = 2'b01; gr_wr_en = 2'b01; gr_wr_data = 16'h1234; cycle("R6 capture beats write");
    gr_cap_mode = 2'b11; run(3, "R6 count");
    cap_trig = 2'b10; cycle("R6 capture B no clear");
    run(3, "R6 after B capture");

    // R9 shared clear
    gr_cap_mode = 2'b00; cfg_clr_sel = 2'b11; run(4, "R9 count");
    sync_en = 0; sync_clr = 1; cycle("R9 sync ignored");
    run(3, "R9 count");
    sync_en = 1; sync_clr = 1; cycle("R9 sync clear");
    run(3, "R9 after clear");
    sync_en = 0;

    // R3 external clock, each edge setting
    do_reset();
    cfg_clk_src = 3'b100;
    for (int es = 0; es < 4; es++) begin
      cfg_edge_sel = es[1:0];
      for (int k = 0; k < 10; k++) begin
        ext_clk_in = ~ext_clk_in;
        run(3, "R3 external edges");
      end
    end

    // R4 phase override
    phase_mode = 1; cfg_edge_sel = 2'b10;
    for (int k = 0; k < 12; k++) begin
      ext_clk_in = ~ext_clk_in;
      phase_step = k[0];
      cycle("R4 phase step only");
    end
    cfg_clk_src = 3'b000;
    run(4, "R4 internal ignored");
    phase_mode = 0;

    // R7 wrap with no clear, R5 match at all-ones
    do_reset();
    cfg_clr_sel = 2'b00; cfg_clk_src = 3'b000;
    run(65540, "R7 R5 wrap");

    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule